// File: doc/BRIEF.md
# Triad Spare Reconfiguration Controller

The controller owns the assignment of processors, memories and buses to a set of redundant triads, plus a small pool of spare units of each kind. When fault identification names a failed unit, the controller decides how to heal the affected triad. It can promote a spare that is already shadowing that triad, or pull a spare away from another triad and then promote it. When no spare processor is left, it retires the triad. When a memory or bus has no spare, it drops the triad to two active units.

Table changes are made only on the fast dispatcher tick, so every change lands on a frame boundary after the request. A one-cycle completion pulse then reports the action taken and the number of fast ticks the recovery took. A repair strobe puts the most recently failed unit back in service, so fault experiments can be repeated without a reset.

Top module: `tsr_reconfig_ctrl`

## Requirements
- R1: After reset, unit u of each kind with u < 3*NUM_TRIADS is ACTIVE in triad u/3, and each spare u is SHADOW of triad (u-3*NUM_TRIADS) mod NUM_TRIADS. Every triad mode reads triplex, req_ready_o is high and done_o is low. Unit state codes are IDLE=0, SHADOW=1, ACTIVE=2, FAILED=3. Kind codes are processor=0, memory=1, bus=2. Mode codes are triplex=0, duplex=1, retired=2.
- R2: Table contents change only at a clock edge where tick_i is high, and done_o pulses for one cycle right after the tick that completes a request.
- R3: If a spare of the failed unit's kind shadows the failed unit's triad, the lowest-index such spare becomes ACTIVE in that triad and the failed unit becomes FAILED, on one tick. The action code is 1.
- R4: A failed processor or memory with no shadow in its own triad takes the lowest-index spare that is IDLE or shadowing another triad. The first tick makes that spare SHADOW of the affected triad and the second tick swaps it in. The action code is 2 and the tick count is 2.
- R5: A failed processor with no spare processor anywhere retires its triad. The unit becomes FAILED, the other ACTIVE processors of the triad become IDLE spares, and the triad mode becomes retired. The action code is 3.
- R6: A failed memory or bus with no shadow in its own triad becomes FAILED and its triad reads duplex. The action code is 4. Bus spares are never relocated between triads, and no triad ever has more than three ACTIVE units of one kind.
- R7: req_ready_o is low from the cycle after a request is accepted until that request completes. A request presented meanwhile is held and taken once the controller is idle.
- R8: A request with kind code 3, an index not below the unit count, or a unit that is not ACTIVE completes after one tick with action code 0 and leaves the table and modes unchanged.
- R9: When the controller is idle, repair_i returns the most recently failed unit on the next edge. The unit becomes ACTIVE if its triad is not retired and has fewer than three ACTIVE units of that kind, and SHADOW of its triad otherwise. The repair is consumed, so a second repair_i has no effect.
- R10: rec_ticks_o gives the number of fast ticks from request acceptance to completion, and is valid while done_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Fast dispatcher tick, one cycle per frame |
| req_valid_i | input | 1 | Failed-unit request valid |
| req_ready_o | output | 1 | Controller can accept a request |
| req_kind_i | input | 2 | Kind of failed unit |
| req_unit_i | input | UW | Index of failed unit within its kind |
| repair_i | input | 1 | Return the most recently failed unit to service |
| done_o | output | 1 | Request completed (one-cycle pulse) |
| done_action_o | output | 3 | Action taken: 0 none, 1 swap, 2 relocate and swap, 3 retire, 4 duplex |
| rec_ticks_o | output | TICK_W | Ticks from acceptance to completion |
| unit_state_o | output | 3*NU*2 | State of unit u of kind k at bits (k*NU+u)*2 +: 2 |
| unit_triad_o | output | 3*NU*TW | Triad of unit u of kind k at bits (k*NU+u)*TW +: TW |
| triad_mode_o | output | 2*NUM_TRIADS | Mode of triad t at bits t*2 +: 2 |

## Verification
The assertions rely on tick_i being a single-cycle pulse separated by idle cycles, and on repair_i being raised only between requests. The assertion on the number of active units also depends on requests arriving one at a time through the handshake. The bench drives every tick as an isolated one-cycle pulse and raises repair only while the controller is idle. It keeps requests valid across a busy period only to exercise the hold-back path, so the stimulus stays within these limits while still reaching relocation, retirement, duplex fallback and repair in sequence.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
  localparam int NUM_KINDS = 3;
  localparam logic [1:0] K_PROC = 2'd0;
  localparam logic [1:0] K_MEM  = 2'd1;
  localparam logic [1:0] K_BUS  = 2'd2;

  typedef enum logic [1:0] {
    U_IDLE   = 2'd0,
    U_SHADOW = 2'd1,
    U_ACTIVE = 2'd2,
    U_FAILED = 2'd3
  } ustate_e;

  typedef enum logic [2:0] {
    OP_NONE, OP_SWAP, OP_MOVE, OP_RETIRE, OP_FAIL, OP_REPAIR
  } op_e;

  typedef enum logic [2:0] {
    ACT_NONE   = 3'd0,
    ACT_SWAP   = 3'd1,
    ACT_RELOC  = 3'd2,
    ACT_RETIRE = 3'd3,
    ACT_DUPLEX = 3'd4
  } act_e;

  typedef enum logic [1:0] {
    M_TRIPLEX = 2'd0,
    M_DUPLEX  = 2'd1,
    M_RETIRED = 2'd2
  } mode_e;
endpackage

// File: rtl/tsr_unit_table.sv
module tsr_unit_table
  import tsr_pkg::*;
#(
  parameter int NT = 2,
  parameter int NU = 7,
  parameter int TW = 1,
  parameter int UW = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  op_e                     op_i,
  input  logic [1:0]              kind_i,
  input  logic [UW-1:0]           unit_a_i,
  input  logic [UW-1:0]           unit_b_i,
  input  logic [TW-1:0]           triad_i,
  output logic [NUM_KINDS*NU*2-1:0]  st_o,
  output logic [NUM_KINDS*NU*TW-1:0] tr_o,
  output logic [NT-1:0]           retired_o
);
  logic [1:0]    st_q [NUM_KINDS][NU];
  logic [TW-1:0] tr_q [NUM_KINDS][NU];
  logic [NT-1:0] ret_q;
  logic          rep_room;

  // room for one more active unit in the repaired unit's triad
  always_comb begin
    int cnt;
    cnt = 0;
    for (int u = 0; u < NU; u++) begin
      if (st_q[kind_i][u] == U_ACTIVE && tr_q[kind_i][u] == tr_q[kind_i][unit_a_i]) cnt++;
    end
    rep_room = (cnt < 3) && !ret_q[tr_q[kind_i][unit_a_i]];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ret_q <= '0;
      for (int k = 0; k < NUM_KINDS; k++) begin
        for (int u = 0; u < NU; u++) begin
          if (u < 3*NT) begin
            st_q[k][u] <= U_ACTIVE;
            tr_q[k][u] <= TW'(u / 3);
          end else begin
            st_q[k][u] <= U_SHADOW;
            tr_q[k][u] <= TW'((u - 3*NT) % NT);
          end
        end
      end
    end else begin
      case (op_i)
        OP_SWAP: begin
          st_q[kind_i][unit_a_i] <= U_FAILED;
          st_q[kind_i][unit_b_i] <= U_ACTIVE;
          tr_q[kind_i][unit_b_i] <= tr_q[kind_i][unit_a_i];
        end
        OP_MOVE: begin
          st_q[kind_i][unit_b_i] <= U_SHADOW;
          tr_q[kind_i][unit_b_i] <= triad_i;
        end
        OP_RETIRE: begin
          for (int u = 0; u < NU; u++) begin
            if (st_q[K_PROC][u] == U_ACTIVE && tr_q[K_PROC][u] == triad_i)
              st_q[K_PROC][u] <= U_IDLE;
          end
          st_q[K_PROC][unit_a_i] <= U_FAILED;
          ret_q[triad_i] <= 1'b1;
        end
        OP_FAIL:   st_q[kind_i][unit_a_i] <= U_FAILED;
        OP_REPAIR: st_q[kind_i][unit_a_i] <= rep_room ? U_ACTIVE : U_SHADOW;
        default: ;
      endcase
    end
  end

  always_comb begin
    for (int k = 0; k < NUM_KINDS; k++) begin
      for (int u = 0; u < NU; u++) begin
        st_o[(k*NU+u)*2 +: 2]   = st_q[k][u];
        tr_o[(k*NU+u)*TW +: TW] = tr_q[k][u];
      end
    end
  end
  assign retired_o = ret_q;

  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_k
    for (genvar u = 0; u < NU; u++) begin : g_u
      a_r9_failed_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q[k][u] == U_FAILED && op_i != OP_REPAIR) |=> st_q[k][u] == U_FAILED);
    end
  end
  for (genvar t = 0; t < NT; t++) begin : g_t
    a_r5_retired_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ret_q[t] |=> ret_q[t]);
  end
endmodule

// File: rtl/tsr_spare_pick.sv
module tsr_spare_pick
  import tsr_pkg::*;
#(
  parameter int NT = 2,
  parameter int NU = 7,
  parameter int TW = 1,
  parameter int UW = 3,
  parameter int CW = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NU*2-1:0]   st_i,
  input  logic [NU*TW-1:0]  tr_i,
  input  logic [TW-1:0]     triad_i,
  output logic              same_vld_o,
  output logic [UW-1:0]     same_idx_o,
  output logic              any_vld_o,
  output logic [UW-1:0]     any_idx_o,
  output logic [NT*CW-1:0]  act_cnt_o
);
  // descending scan: lowest index wins
  always_comb begin
    logic [1:0]    s;
    logic [TW-1:0] t;
    same_vld_o = 1'b0;
    same_idx_o = '0;
    any_vld_o  = 1'b0;
    any_idx_o  = '0;
    for (int u = NU-1; u >= 0; u--) begin
      s = st_i[u*2 +: 2];
      t = tr_i[u*TW +: TW];
      if (s == U_SHADOW && t == triad_i) begin
        same_vld_o = 1'b1;
        same_idx_o = UW'(u);
      end
      if (s == U_IDLE || (s == U_SHADOW && t != triad_i)) begin
        any_vld_o = 1'b1;
        any_idx_o = UW'(u);
      end
    end
  end

  always_comb begin
    int c;
    for (int tt = 0; tt < NT; tt++) begin
      c = 0;
      for (int u = 0; u < NU; u++) begin
        if (st_i[u*2 +: 2] == U_ACTIVE && tr_i[u*TW +: TW] == TW'(tt)) c++;
      end
      act_cnt_o[tt*CW +: CW] = CW'(c);
    end
  end

  for (genvar tt = 0; tt < NT; tt++) begin : g_cnt
    a_r6_active_le3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      int'(act_cnt_o[tt*CW +: CW]) <= 3);
  end
endmodule

// File: rtl/tsr_mode.sv
module tsr_mode
  import tsr_pkg::*;
#(
  parameter int NT = 2,
  parameter int CW = 3
) (
  input  logic [NT*CW-1:0] cnt_proc_i,
  input  logic [NT*CW-1:0] cnt_mem_i,
  input  logic [NT*CW-1:0] cnt_bus_i,
  input  logic [NT-1:0]    retired_i,
  output logic [NT*2-1:0]  mode_o
);
  for (genvar t = 0; t < NT; t++) begin : g_t
    logic short_w;
    assign short_w = int'(cnt_proc_i[t*CW +: CW]) < 3 ||
                     int'(cnt_mem_i[t*CW +: CW])  < 3 ||
                     int'(cnt_bus_i[t*CW +: CW])  < 3;
    assign mode_o[t*2 +: 2] = retired_i[t] ? M_RETIRED :
                              short_w      ? M_DUPLEX  : M_TRIPLEX;
  end
endmodule

// File: rtl/tsr_reconfig_ctrl.sv
module tsr_reconfig_ctrl
  import tsr_pkg::*;
#(
  parameter int NUM_TRIADS = 2,
  parameter int NUM_SPARES = 1,
  parameter int TICK_W     = 8,
  localparam int NU = 3*NUM_TRIADS + NUM_SPARES,
  localparam int UW = (NU > 1) ? $clog2(NU) : 1,
  localparam int TW = (NUM_TRIADS > 1) ? $clog2(NUM_TRIADS) : 1,
  localparam int CW = $clog2(NU+1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      tick_i,
  input  logic                      req_valid_i,
  output logic                      req_ready_o,
  input  logic [1:0]                req_kind_i,
  input  logic [UW-1:0]             req_unit_i,
  input  logic                      repair_i,
  output logic                      done_o,
  output logic [2:0]                done_action_o,
  output logic [TICK_W-1:0]         rec_ticks_o,
  output logic [NUM_KINDS*NU*2-1:0]  unit_state_o,
  output logic [NUM_KINDS*NU*TW-1:0] unit_triad_o,
  output logic [NUM_TRIADS*2-1:0]   triad_mode_o
);
  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_STEP2} state_e;

  state_e              state_q;
  logic [1:0]          kind_q, last_kind_q;
  logic [UW-1:0]       unit_q, spare_q, last_unit_q;
  logic                last_vld_q;
  logic [TICK_W-1:0]   cnt_q, ticks_q;
  logic                done_q;
  act_e                act_q;

  logic [NUM_KINDS*NU*2-1:0]  st_w;
  logic [NUM_KINDS*NU*TW-1:0] tr_w;
  logic [NUM_TRIADS-1:0]      ret_w;
  logic [NUM_KINDS-1:0]       same_vld, any_vld;
  logic [UW-1:0]              same_idx [NUM_KINDS];
  logic [UW-1:0]              any_idx  [NUM_KINDS];
  logic [NUM_TRIADS*CW-1:0]   act_cnt  [NUM_KINDS];

  logic          accept;
  logic [1:0]    kq;
  int            uc;
  logic [1:0]    st_sel;
  logic [TW-1:0] tr_sel;
  logic          req_ok;
  op_e           dec_op, op_c;
  act_e          dec_act;
  logic          dec_move;
  logic [UW-1:0] dec_b, op_b;
  logic [1:0]    op_kind;
  logic [UW-1:0] op_a;

  assign req_ready_o = (state_q == S_IDLE);
  assign accept      = req_valid_i && req_ready_o;

  // selected request view (clamped so indexing stays in range)
  assign kq     = (kind_q == 2'd3) ? K_PROC : kind_q;
  assign uc     = (int'(unit_q) < NU) ? int'(unit_q) : 0;
  assign st_sel = st_w[(int'(kq)*NU + uc)*2 +: 2];
  assign tr_sel = tr_w[(int'(kq)*NU + uc)*TW +: TW];
  assign req_ok = (kind_q != 2'd3) && (int'(unit_q) < NU) && (st_sel == U_ACTIVE);

  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_pick
    tsr_spare_pick #(.NT(NUM_TRIADS), .NU(NU), .TW(TW), .UW(UW), .CW(CW)) u_pick (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .st_i       (st_w[k*NU*2 +: NU*2]),
      .tr_i       (tr_w[k*NU*TW +: NU*TW]),
      .triad_i    (tr_sel),
      .same_vld_o (same_vld[k]),
      .same_idx_o (same_idx[k]),
      .any_vld_o  (any_vld[k]),
      .any_idx_o  (any_idx[k]),
      .act_cnt_o  (act_cnt[k])
    );
  end

  // policy: swap, relocate (proc/mem), retire (proc), duplex (mem/bus)
  always_comb begin
    dec_op   = OP_NONE;
    dec_act  = ACT_NONE;
    dec_move = 1'b0;
    dec_b    = '0;
    if (req_ok) begin
      if (same_vld[kq]) begin
        dec_op  = OP_SWAP;
        dec_act = ACT_SWAP;
        dec_b   = same_idx[kq];
      end else if (kq != K_BUS && any_vld[kq]) begin
        dec_op   = OP_MOVE;
        dec_act  = ACT_RELOC;
        dec_move = 1'b1;
        dec_b    = any_idx[kq];
      end else if (kq == K_PROC) begin
        dec_op  = OP_RETIRE;
        dec_act = ACT_RETIRE;
      end else begin
        dec_op  = OP_FAIL;
        dec_act = ACT_DUPLEX;
      end
    end
  end

  always_comb begin
    op_c    = OP_NONE;
    op_kind = kq;
    op_a    = unit_q;
    op_b    = dec_b;
    case (state_q)
      S_WAIT:  if (tick_i) op_c = dec_op;
      S_STEP2: if (tick_i) begin
        op_c = OP_SWAP;
        op_b = spare_q;
      end
      default: if (repair_i && last_vld_q && !accept) begin
        op_c    = OP_REPAIR;
        op_kind = last_kind_q;
        op_a    = last_unit_q;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      kind_q      <= '0;
      unit_q      <= '0;
      spare_q     <= '0;
      cnt_q       <= '0;
      ticks_q     <= '0;
      done_q      <= 1'b0;
      act_q       <= ACT_NONE;
      last_vld_q  <= 1'b0;
      last_kind_q <= '0;
      last_unit_q <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        S_IDLE: if (accept) begin
          kind_q  <= req_kind_i;
          unit_q  <= req_unit_i;
          cnt_q   <= '0;
          state_q <= S_WAIT;
        end
        S_WAIT: if (tick_i) begin
          cnt_q <= cnt_q + 1'b1;
          if (dec_move) begin
            spare_q <= dec_b;
            state_q <= S_STEP2;
          end else begin
            state_q <= S_IDLE;
            done_q  <= 1'b1;
            act_q   <= dec_act;
            ticks_q <= cnt_q + 1'b1;
          end
        end
        S_STEP2: if (tick_i) begin
          state_q <= S_IDLE;
          done_q  <= 1'b1;
          act_q   <= ACT_RELOC;
          ticks_q <= cnt_q + 1'b1;
        end
        default: state_q <= S_IDLE;
      endcase
      if (op_c == OP_SWAP || op_c == OP_RETIRE || op_c == OP_FAIL) begin
        last_vld_q  <= 1'b1;
        last_kind_q <= kq;
        last_unit_q <= unit_q;
      end else if (op_c == OP_REPAIR) begin
        last_vld_q  <= 1'b0;
      end
    end
  end

  tsr_unit_table #(.NT(NUM_TRIADS), .NU(NU), .TW(TW), .UW(UW)) u_table (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .op_i      (op_c),
    .kind_i    (op_kind),
    .unit_a_i  (op_a),
    .unit_b_i  (op_b),
    .triad_i   (tr_sel),
    .st_o      (st_w),
    .tr_o      (tr_w),
    .retired_o (ret_w)
  );

  tsr_mode #(.NT(NUM_TRIADS), .CW(CW)) u_mode (
    .cnt_proc_i (act_cnt[0]),
    .cnt_mem_i  (act_cnt[1]),
    .cnt_bus_i  (act_cnt[2]),
    .retired_i  (ret_w),
    .mode_o     (triad_mode_o)
  );

  assign unit_state_o  = st_w;
  assign unit_triad_o  = tr_w;
  assign done_o        = done_q;
  assign done_action_o = act_q;
  assign rec_ticks_o   = ticks_q;

  a_r2_done_after_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(tick_i));
  a_r7_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);
  a_r10_ticks_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (rec_ticks_o == TICK_W'(1) || rec_ticks_o == TICK_W'(2)));
  a_r4_reloc_two_ticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && done_action_o == ACT_RELOC) |-> rec_ticks_o == TICK_W'(2));
endmodule

// File: tb/tsr_reconfig_ctrl_bench.sv
module tsr_reconfig_ctrl_bench;
  localparam int NT = 2;
  localparam int NU = 7;
  localparam int TW = 1;
  localparam int UW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_kind = '0;
  logic [UW-1:0] req_unit = '0;
  logic repair = 1'b0;
  logic req_ready, done;
  logic [2:0] done_action;
  logic [7:0] rec_ticks;
  logic [3*NU*2-1:0]  unit_state;
  logic [3*NU*TW-1:0] unit_triad;
  logic [NT*2-1:0]    triad_mode;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  tsr_reconfig_ctrl u_tsr_reconfig_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_kind_i(req_kind), .req_unit_i(req_unit), .repair_i(repair),
    .done_o(done), .done_action_o(done_action), .rec_ticks_o(rec_ticks),
    .unit_state_o(unit_state), .unit_triad_o(unit_triad), .triad_mode_o(triad_mode)
  );

  function automatic int st_of(int k, int u);
    return int'(unit_state[(k*NU+u)*2 +: 2]);
  endfunction
  function automatic int tr_of(int k, int u);
    return int'(unit_triad[(k*NU+u)*TW +: TW]);
  endfunction
  function automatic int mode_of(int t);
    return int'(triad_mode[t*2 +: 2]);
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic issue(int k, int u);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_kind  = 2'(k);
    req_unit  = UW'(u);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic tick_pulse();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic expect_done(string req, int act, int ticks);
    chk(req, "done", int'(done), 1);
    chk(req, "action", int'(done_action), act);
    chk("R10", "ticks", int'(rec_ticks), ticks);
  endtask

  task automatic test_reset();
    for (int k = 0; k < 3; k++) begin
      for (int u = 0; u < NU; u++) begin
        chk("R1", "state", st_of(k, u), (u < 3*NT) ? 2 : 1);
        chk("R1", "triad", tr_of(k, u), (u < 3*NT) ? u/3 : (u-3*NT)%NT);
      end
    end
    chk("R1", "mode0", mode_of(0), 0);
    chk("R1", "mode1", mode_of(1), 0);
    chk("R1", "ready", int'(req_ready), 1);
    chk("R1", "done", int'(done), 0);
  endtask

  task automatic test_bus_duplex();
    issue(2, 4);
    repeat (3) @(negedge clk);
    chk("R2", "no change before tick", st_of(2, 4), 2);
    chk("R2", "no done before tick", int'(done), 0);
    tick_pulse();
    expect_done("R6", 4, 1);
    chk("R6", "bus4 failed", st_of(2, 4), 3);
    chk("R6", "bus spare not moved", st_of(2, 6), 1);
    chk("R6", "bus spare triad", tr_of(2, 6), 0);
    chk("R6", "triad1 duplex", mode_of(1), 1);
    @(negedge clk);
    chk("R2", "done one cycle", int'(done), 0);
  endtask

  task automatic test_proc_swap();
    issue(0, 1);
    tick_pulse();
    expect_done("R3", 1, 1);
    chk("R3", "p1 failed", st_of(0, 1), 3);
    chk("R3", "p6 active", st_of(0, 6), 2);
    chk("R3", "p6 triad", tr_of(0, 6), 0);
    chk("R3", "triad0 triplex", mode_of(0), 0);
  endtask

  task automatic test_retire();
    issue(0, 4);
    tick_pulse();
    expect_done("R5", 3, 1);
    chk("R5", "p4 failed", st_of(0, 4), 3);
    chk("R5", "p3 idle", st_of(0, 3), 0);
    chk("R5", "p5 idle", st_of(0, 5), 0);
    chk("R5", "triad1 retired", mode_of(1), 2);
  endtask

  task automatic test_proc_reloc();
    issue(0, 0);
    tick_pulse();
    chk("R4", "no done after first tick", int'(done), 0);
    chk("R4", "p3 shadow", st_of(0, 3), 1);
    chk("R4", "p3 triad", tr_of(0, 3), 0);
    chk("R4", "p0 still active", st_of(0, 0), 2);
    tick_pulse();
    expect_done("R4", 2, 2);
    chk("R4", "p0 failed", st_of(0, 0), 3);
    chk("R4", "p3 active", st_of(0, 3), 2);
    chk("R4", "p5 untouched", st_of(0, 5), 0);
    chk("R4", "triad0 triplex", mode_of(0), 0);
  endtask

  task automatic test_mem_reloc();
    issue(1, 4);
    tick_pulse();
    chk("R4", "m6 shadow", st_of(1, 6), 1);
    chk("R4", "m6 moved", tr_of(1, 6), 1);
    tick_pulse();
    expect_done("R4", 2, 2);
    chk("R4", "m4 failed", st_of(1, 4), 3);
    chk("R4", "m6 active", st_of(1, 6), 2);
    chk("R4", "m6 triad", tr_of(1, 6), 1);
  endtask

  task automatic test_mem_duplex();
    issue(1, 0);
    tick_pulse();
    expect_done("R6", 4, 1);
    chk("R6", "m0 failed", st_of(1, 0), 3);
    chk("R6", "triad0 duplex", mode_of(0), 1);
  endtask

  task automatic test_repair();
    logic [3*NU*2-1:0]  s0;
    logic [3*NU*TW-1:0] t0;
    logic [NT*2-1:0]    m0;
    @(negedge clk);
    repair = 1'b1;
    @(negedge clk);
    repair = 1'b0;
    chk("R9", "m0 active", st_of(1, 0), 2);
    chk("R9", "m0 triad", tr_of(1, 0), 0);
    chk("R9", "triad0 triplex", mode_of(0), 0);
    s0 = unit_state; t0 = unit_triad; m0 = triad_mode;
    repair = 1'b1;
    @(negedge clk);
    repair = 1'b0;
    @(negedge clk);
    chk("R9", "second repair state", int'(unit_state == s0), 1);
    chk("R9", "second repair triad", int'(unit_triad == t0), 1);
    chk("R9", "second repair mode", int'(triad_mode == m0), 1);
  endtask

  task automatic test_hold_back();
    issue(2, 0);
    chk("R7", "busy", int'(req_ready), 0);
    req_valid = 1'b1;
    req_kind  = 2'd2;
    req_unit  = UW'(1);
    repeat (3) @(negedge clk);
    chk("R7", "still busy", int'(req_ready), 0);
    chk("R7", "b1 untouched", st_of(2, 1), 2);
    tick_pulse();
    expect_done("R3", 1, 1);
    chk("R3", "b0 failed", st_of(2, 0), 3);
    chk("R3", "b6 active", st_of(2, 6), 2);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R7", "held request taken", int'(req_ready), 0);
    tick_pulse();
    expect_done("R7", 4, 1);
    chk("R7", "b1 failed", st_of(2, 1), 3);
    chk("R6", "triad0 duplex", mode_of(0), 1);
  endtask

  task automatic test_ignored(int k, int u, string tag);
    logic [3*NU*2-1:0]  s0;
    logic [3*NU*TW-1:0] t0;
    logic [NT*2-1:0]    m0;
    s0 = unit_state; t0 = unit_triad; m0 = triad_mode;
    issue(k, u);
    tick_pulse();
    expect_done("R8", 0, 1);
    chk("R8", {tag, " state"}, int'(unit_state == s0), 1);
    chk("R8", {tag, " triad"}, int'(unit_triad == t0), 1);
    chk("R8", {tag, " mode"}, int'(triad_mode == m0), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_bus_duplex();
    test_proc_swap();
    test_retire();
    test_proc_reloc();
    test_mem_reloc();
    test_mem_duplex();
    test_repair();
    test_hold_back();
    test_ignored(3, 0, "kind3");
    test_ignored(0, 1, "failed unit");
    test_ignored(0, 7, "index range");
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule